// File: doc/BRIEF.md
# Resolution-Selectable Temperature Conversion Sequencer

This block decides when a temperature conversion runs and keeps the most recent result. The analog converter is outside the block. A 12-bit sample port stands in for the converter, and the block captures that port when each conversion ends. The length of a conversion is a base number of clock cycles multiplied by 1, 2, 4 or 8, as set by a 2-bit resolution code. The captured value is cut down to the selected resolution and stored in a 12-bit two's complement temperature register with 0.0625 degree per LSB.

When the shutdown bit is low, conversions run back to back. When the shutdown bit is high, the block stops, but only after the conversion already in progress has finished. While the block is stopped, a configuration write that carries a one-shot bit of 1 starts exactly one conversion. Each stored result comes with a one-cycle done pulse, which the alert logic downstream uses. A busy flag shows when a conversion is in progress.

Top module: `tconv_sequencer`

## Requirements
- R1: While reset is held, tempReg reads 0 and busy and convDone are 0. With cfgShutdown=0, busy goes high on the first clock edge after reset is released.
- R2: The resolution code maps as 0=9 bits, 1=10 bits, 2=11 bits and 3=12 bits. A conversion lasts BASE_CYCLES x 2^code clock cycles, counted from the edge that starts it to the edge that stores its result.
- R3: With cfgShutdown=0, a new conversion starts in the same edge that stores the previous result. Done pulses are therefore exactly one conversion length apart, and busy stays high.
- R4: The stored value is rawSample with its (3 - code) least significant bits forced to zero. The upper bits are kept unchanged.
- R5: Raising cfgShutdown during a conversion does not cut that conversion short. It still completes and stores its result. Busy then falls in that same edge and no further conversion starts.
- R6: While idle in shutdown, a cycle with cfgWriteStb=1 and cfgOs=1 makes busy high on the next edge. That conversion gives exactly one result, and the block then stays idle. A write with cfgOs=0 starts nothing.
- R7: A one-shot write that arrives while a conversion is running is ignored. It neither restarts the conversion nor adds a conversion.
- R8: The resolution code is latched when a conversion starts. A change made during a conversion affects only the length and truncation of later conversions.
- R9: convDone is a one-cycle pulse in the cycle that tempReg takes a new result, and it follows a busy cycle. tempReg does not change in any other cycle.
- R10: Two's complement values pass through unchanged at 12 bits. For example, -55 degrees (0xC90) is stored as 0xC90.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgShutdown | input | 1 | 1 = stop after the current conversion, 0 = continuous |
| cfgResolution | input | 2 | Resolution code, 0..3 = 9..12 bits |
| cfgOs | input | 1 | One-shot bit of the configuration write data |
| cfgWriteStb | input | 1 | One-cycle strobe for a configuration write |
| rawSample | input | SAMPLE_W | Converter output, captured at the end of a conversion |
| tempReg | output | SAMPLE_W | Last stored result, truncated |
| convDone | output | 1 | One-cycle pulse when a new result is stored |
| busy | output | 1 | A conversion is in progress |

## Verification
Continuous conversion is run at each of the four resolution codes, with positive and negative samples whose low bits are set. This separates correct truncation from a pass-through, and the spacing of the pulses separates the four lengths. Resolution changes are written in the middle of a conversion. This checks that the old length and mask apply to the conversion that is running and the new ones only after it. Shutdown raised partway through a conversion, one-shot writes with the bit set and clear, and a second one-shot during a running conversion separate a finish-first stop from an abrupt one, and a single conversion from a restarted or repeated one.

// File: rtl/tconv_pkg.sv
package tconv_pkg;
  // number of selectable resolutions; code 0 is the coarsest
  localparam int RES_STEPS = 4;
  localparam int RES_W     = 2;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic startConv;   // load the length counter and latch the resolution
    logic storeResult; // capture the truncated sample and pulse done
  } seqStrobe_t;
endpackage

// File: rtl/tconv_control.sv
module tconv_control
  import tconv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgShutdown,
  input  logic       cfgOs,
  input  logic       cfgWriteStb,
  input  logic       countZero,
  output seqStrobe_t strb,
  output logic       busy
);
  seqState_e state, stateNext;
  logic oneShotReq;

  assign oneShotReq = cfgWriteStb && cfgOs;

  always_comb begin
    stateNext        = state;
    strb.startConv   = 1'b0;
    strb.storeResult = 1'b0;
    unique case (state)
      ST_IDLE: begin
        // continuous mode restarts by itself; shutdown waits for a one-shot
        if (!cfgShutdown || oneShotReq) begin
          strb.startConv = 1'b1;
          stateNext      = ST_CONV;
        end
      end
      ST_CONV: begin
        // one-shot writes are not looked at here: a running conversion ignores them
        if (countZero) begin
          strb.storeResult = 1'b1;
          if (!cfgShutdown) begin
            strb.startConv = 1'b1;
          end else begin
            stateNext = ST_IDLE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state == ST_CONV);
endmodule

// File: rtl/tconv_datapath.sv
module tconv_datapath
  import tconv_pkg::*;
#(
  parameter int BASE_CYCLES = 16,
  parameter int SAMPLE_W    = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strb,
  input  logic [RES_W-1:0]    cfgResolution,
  input  logic [SAMPLE_W-1:0] rawSample,
  output logic                countZero,
  output logic [SAMPLE_W-1:0] tempReg,
  output logic                convDone
);
  localparam int MAX_LEN = BASE_CYCLES * (1 << (RES_STEPS - 1));
  localparam int CNT_W   = $clog2(MAX_LEN) + 1;

  logic [CNT_W-1:0]    remain;
  logic [RES_W-1:0]    resLatched;
  logic [CNT_W-1:0]    lenTable  [RES_STEPS];
  logic [SAMPLE_W-1:0] maskTable [RES_STEPS];

  // one length and one keep-mask per resolution code
  for (genvar g = 0; g < RES_STEPS; g++) begin : g_res
    assign lenTable[g]  = CNT_W'(BASE_CYCLES << g) - CNT_W'(1);
    assign maskTable[g] = {SAMPLE_W{1'b1}} << (RES_STEPS - 1 - g);
  end

  assign countZero = (remain == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remain     <= '0;
      resLatched <= '0;
      tempReg    <= '0;
      convDone   <= 1'b0;
    end else begin
      convDone <= strb.storeResult;
      if (strb.storeResult) begin
        tempReg <= rawSample & maskTable[resLatched];
      end
      if (strb.startConv) begin
        remain     <= lenTable[cfgResolution];
        resLatched <= cfgResolution;
      end else if (!countZero) begin
        remain <= remain - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/tconv_sequencer.sv
module tconv_sequencer
  import tconv_pkg::*;
#(
  parameter int BASE_CYCLES = 16,
  parameter int SAMPLE_W    = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgShutdown,
  input  logic [1:0]          cfgResolution,
  input  logic                cfgOs,
  input  logic                cfgWriteStb,
  input  logic [SAMPLE_W-1:0] rawSample,
  output logic [SAMPLE_W-1:0] tempReg,
  output logic                convDone,
  output logic                busy
);
  seqStrobe_t strb;
  logic       countZero;

  tconv_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgShutdown(cfgShutdown),
    .cfgOs      (cfgOs),
    .cfgWriteStb(cfgWriteStb),
    .countZero  (countZero),
    .strb       (strb),
    .busy       (busy)
  );

  tconv_datapath #(
    .BASE_CYCLES(BASE_CYCLES),
    .SAMPLE_W   (SAMPLE_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .cfgResolution(cfgResolution),
    .rawSample    (rawSample),
    .countZero    (countZero),
    .tempReg      (tempReg),
    .convDone     (convDone)
  );
endmodule

// File: rtl/tconv_sequencer_chk.sv
module tconv_sequencer_chk
  import tconv_pkg::*;
#(
  parameter int BASE_CYCLES = 16,
  parameter int SAMPLE_W    = 12
) (
  input logic                clk,
  input logic                rstN,
  input logic                cfgShutdown,
  input logic [1:0]          cfgResolution,
  input logic                cfgOs,
  input logic                cfgWriteStb,
  input logic                busy,
  input logic                convDone,
  input logic [SAMPLE_W-1:0] tempReg,
  input seqStrobe_t          strb
);
  localparam int ELW = $clog2(BASE_CYCLES * 8) + 2;

  logic [ELW-1:0] elapsed;
  logic [1:0]     curRes;
  logic [1:0]     doneRes;

  function automatic logic [SAMPLE_W-1:0] dropMask(input logic [1:0] r);
    return ~({SAMPLE_W{1'b1}} << (3 - int'(r)));
  endfunction

  // independent cycle counter for the conversion window
  always_ff @(posedge clk) begin
    if (!rstN) begin
      elapsed <= '0;
      curRes  <= '0;
      doneRes <= '0;
    end else begin
      if (strb.startConv) begin
        elapsed <= ELW'(1);
        curRes  <= cfgResolution;
      end else if (busy) begin
        elapsed <= elapsed + ELW'(1);
      end
      if (strb.storeResult) doneRes <= curRes;
    end
  end

  a_r2_conv_length: assert property (@(posedge clk) disable iff (!rstN)
    strb.storeResult |-> (elapsed == ELW'(BASE_CYCLES << curRes)));

  a_r4_low_bits_clear: assert property (@(posedge clk) disable iff (!rstN)
    convDone |-> ((tempReg & dropMask(doneRes)) == '0));

  a_r3_auto_restart: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !cfgShutdown) |=> busy);

  a_r5_busy_until_store: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.storeResult) |=> busy);

  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cfgShutdown && !(cfgWriteStb && cfgOs)) |=> !busy);

  a_r9_result_stable: assert property (@(posedge clk) disable iff (!rstN)
    !convDone |-> $stable(tempReg));

  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    convDone |-> $past(busy));
endmodule

bind tconv_sequencer tconv_sequencer_chk #(
  .BASE_CYCLES(BASE_CYCLES),
  .SAMPLE_W   (SAMPLE_W)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .cfgShutdown  (cfgShutdown),
  .cfgResolution(cfgResolution),
  .cfgOs        (cfgOs),
  .cfgWriteStb  (cfgWriteStb),
  .busy         (busy),
  .convDone     (convDone),
  .tempReg      (tempReg),
  .strb         (strb)
);

// File: tb/tconv_sequencer_test.sv
`timescale 1ns/1ps
module tconv_sequencer_test;
  localparam int BASE = 4;
  localparam int SW   = 12;

  logic          clk = 1'b0;
  logic          rstN;
  logic          cfgShutdown;
  logic [1:0]    cfgResolution;
  logic          cfgOs;
  logic          cfgWriteStb;
  logic [SW-1:0] rawSample;
  logic [SW-1:0] tempReg;
  logic          convDone;
  logic          busy;

  always #10 clk = ~clk;

  tconv_sequencer #(.BASE_CYCLES(BASE), .SAMPLE_W(SW)) uut (
    .clk(clk), .rstN(rstN), .cfgShutdown(cfgShutdown), .cfgResolution(cfgResolution),
    .cfgOs(cfgOs), .cfgWriteStb(cfgWriteStb), .rawSample(rawSample),
    .tempReg(tempReg), .convDone(convDone), .busy(busy)
  );

  typedef struct {
    logic [SW-1:0] value;
    int            gap;   // expected cycles since previous done, 0 = unchecked
    string         tag;
  } expItem_t;

  expItem_t      expQ[$];
  expItem_t      monItem;
  int            checks = 0;
  int            errors = 0;
  int            cyc = 0;
  int            lastDone = 0;
  logic [SW-1:0] prevTemp = '0;
  bit            finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [SW-1:0] v, input int gap, input string tag);
    expItem_t it;
    it.value = v; it.gap = gap; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic waitDone(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!convDone && n < 1000);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      if (convDone) begin
        if (expQ.size() == 0) begin
          check(0, "R9", "unexpected done pulse", 1, 0);
        end else begin
          monItem = expQ.pop_front();
          check(tempReg == monItem.value, monItem.tag, "stored result",
                int'(tempReg), int'(monItem.value));
          if (monItem.gap > 0)
            check(cyc - lastDone == monItem.gap, "R3", "done spacing",
                  cyc - lastDone, monItem.gap);
        end
        lastDone = cyc;
      end else if (tempReg != prevTemp) begin
        check(0, "R9", "tempReg changed without done", int'(tempReg), int'(prevTemp));
      end
      prevTemp = tempReg;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  // count cycles in a window where busy must stay low
  task automatic idleWindow(input int len, input string req);
    int seen;
    seen = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (busy) seen++;
    end
    check(seen == 0, req, "busy cycles while idle", seen, 0);
  endtask

  initial begin
    int n;
    rstN = 0; cfgShutdown = 0; cfgResolution = 2'd0; cfgOs = 0; cfgWriteStb = 0;
    rawSample = 12'h191;
    repeat (3) @(negedge clk);
    check(tempReg == 0, "R1", "tempReg in reset", int'(tempReg), 0);
    check(busy == 0, "R1", "busy in reset", int'(busy), 0);
    check(convDone == 0, "R1", "done in reset", int'(convDone), 0);

    push(12'h190, 0, "R1");
    rstN = 1;
    @(negedge clk);
    check(busy == 1, "R1", "busy after release", int'(busy), 1);
    waitDone(n);
    check(n == BASE, "R2", "first 9-bit length", n, BASE);

    rawSample = 12'hC97; push(12'hC90, BASE, "R4");            waitDone(n);
    cfgResolution = 2'd3;
    rawSample = 12'h7FF; push(12'h7F8, BASE, "R8");            waitDone(n);
    push(12'h7FF, BASE * 8, "R2");                             waitDone(n);
    cfgResolution = 2'd1;
    rawSample = 12'hC90; push(12'hC90, BASE * 8, "R10");       waitDone(n);
    push(12'hC90, BASE * 2, "R2");                             waitDone(n);
    rawSample = 12'h193; push(12'h190, BASE * 2, "R4");        waitDone(n);
    cfgResolution = 2'd2;
    rawSample = 12'h4B7; push(12'h4B4, BASE * 2, "R8");        waitDone(n);
    push(12'h4B6, BASE * 4, "R2");                             waitDone(n);

    // R5: shutdown raised mid-conversion
    push(12'h4B6, BASE * 4, "R5");
    repeat (5) @(negedge clk);
    cfgShutdown = 1;
    waitDone(n);
    check(busy == 0, "R5", "busy after final store", int'(busy), 0);
    idleWindow(40, "R5");

    // R6: one-shot from shutdown
    cfgResolution = 2'd0;
    rawSample = 12'h320;
    push(12'h320, 0, "R6");
    cfgWriteStb = 1; cfgOs = 1;
    @(negedge clk);
    cfgWriteStb = 0; cfgOs = 0;
    check(busy == 1, "R6", "busy after one-shot", int'(busy), 1);
    waitDone(n);
    check(n == BASE, "R6", "one-shot length", n, BASE);
    idleWindow(30, "R6");

    // R6: write with one-shot bit clear starts nothing
    cfgWriteStb = 1; cfgOs = 0;
    @(negedge clk);
    cfgWriteStb = 0;
    idleWindow(10, "R6");

    // R7: second one-shot during a running conversion is ignored
    rawSample = 12'hE70;
    push(12'hE70, 0, "R7");
    cfgWriteStb = 1; cfgOs = 1;
    @(negedge clk);
    cfgWriteStb = 0; cfgOs = 0;
    @(negedge clk);
    cfgWriteStb = 1; cfgOs = 1;
    @(negedge clk);
    cfgWriteStb = 0; cfgOs = 0;
    waitDone(n);
    check(n == BASE - 2, "R7", "length unchanged by repeat write", n, BASE - 2);
    idleWindow(30, "R7");

    check(expQ.size() == 0, "R9", "missing done pulses", expQ.size(), 0);
    finishRun();
  end
endmodule